// File: doc/BRIEF.md
# Prioritised configuration register with byte and bit writes

This block holds one 16-bit configuration word that two agents can change. The processor side writes it through a bus port. That port takes a full-word write, a single-byte write selected by per-byte strobes, or a set/clear of one addressed bit, because the register is bit-addressable. The hardware side is used by internal logic. It can change any group of bits through a mask and a value. The stored word is always presented on a registered read output.

Two rules shape how writes behave. When software and hardware both act in the same cycle, the software write is taken and the hardware change is discarded. A byte write that touches only one byte zeroes the other byte of the word. Bit positions outside the implemented-bit mask never store anything and always read 0. Under synchronous reset the word takes a fixed value, except for three strap bits, which are copied from configuration pins sampled while reset is held. Address decoding and the functions the bits drive belong to the surrounding logic.

Top module: `sfr_cfg_reg`

## Requirements
- R1: When a processor write that takes effect and a hardware update occur in the same cycle, the register takes the processor result, and the hardware mask and value have no effect that cycle.
- R2: A write with cpu_wr_kind = 0 (word) loads every implemented bit from cpu_wdata. A write with cpu_wr_kind = 1 (byte) and both strobes set does the same.
- R3: A write with cpu_wr_kind = 1 and exactly one strobe set loads the addressed byte from cpu_wdata and forces the other byte to zero. Strobe cpu_byte_en[0] selects bits 7:0, and strobe cpu_byte_en[1] selects bits 15:8.
- R4: A byte write with both strobes clear is not a processor write. The register keeps its value, or takes a hardware update requested in the same cycle.
- R5: A write with cpu_wr_kind = 2 (bit) sets bit cpu_bit_idx to cpu_bit_val and leaves every other bit unchanged. No byte is cleared.
- R6: A hardware update with no processor write replaces only the bits where hw_mask is 1 with hw_value. The bits where hw_mask is 0 keep their value.
- R7: Bits outside IMPL_MASK read 0 after every source: reset, word, byte, bit and hardware writes. The default IMPL_MASK is 16'h7FEF, which makes bits 15 and 4 reserved.
- R8: While rst is high at a clock edge, the register loads 0, except for bits 10, 9 and 7. Those three bits take cfg_pins[10], cfg_pins[9] and cfg_pins[7]. The other cfg_pins bits are ignored.
- R9: rd_data is registered. During the cycle of a write it still shows the old value, and the new value appears after the next clock edge.
- R10: cpu_wr_kind = 3 is not a processor write. With no hardware update in that cycle the register holds, and with no write of either kind the register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap pins are sampled while it is high |
| cfg_pins | input | 16 | Strap inputs; only bits 10, 9 and 7 are used |
| cpu_wr_en | input | 1 | Processor write request |
| cpu_wr_kind | input | 2 | 0 word, 1 byte, 2 bit, 3 no write |
| cpu_byte_en | input | 2 | Byte strobes for byte writes; bit 0 low byte, bit 1 high byte |
| cpu_wdata | input | 16 | Processor write data |
| cpu_bit_idx | input | 4 | Target bit for bit writes |
| cpu_bit_val | input | 1 | Value given to the target bit |
| hw_wr_en | input | 1 | Hardware update request |
| hw_mask | input | 16 | Bits that the hardware update changes |
| hw_value | input | 16 | New values for the masked bits |
| rd_data | output | 16 | Current register contents |

## Verification
The hardest case to reach is a collision between the two writers while the word holds a mix of ones and zeros. Only then is it visible that the software result wins and the hardware mask has no effect. Directed cycles first fill the word, then issue word, single-byte and bit writes together with opposing hardware updates. A seeded random phase then turns on both writers at high rates, using all write kinds and all strobe patterns, including the empty strobe case where the hardware update has to get through.

// File: rtl/sfr_cfg_pkg.sv
package sfr_cfg_pkg;

    localparam int unsigned DW     = 16;
    localparam int unsigned BW     = 8;
    localparam int unsigned NBYTES = DW / BW;
    localparam int unsigned IDXW   = $clog2(DW);

    typedef enum logic [1:0] {
        WK_WORD = 2'd0,
        WK_BYTE = 2'd1,
        WK_BIT  = 2'd2,
        WK_NONE = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] val;
    } upd_t;

    function automatic logic [DW-1:0] one_hot_bit(input logic [IDXW-1:0] idx);
        logic [DW-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] strap_value(input logic [DW-1:0] rst_val,
                                                  input logic [DW-1:0] load_mask,
                                                  input logic [DW-1:0] pins);
        return (rst_val & ~load_mask) | (pins & load_mask);
    endfunction

endpackage

// File: rtl/sfr_cpu_wr.sv
module sfr_cpu_wr
    import sfr_cfg_pkg::*;
(
    input  logic [DW-1:0]     q,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [NBYTES-1:0] byte_en,
    input  logic [DW-1:0]     wdata,
    input  logic [IDXW-1:0]   bit_idx,
    input  logic              bit_val,
    output upd_t              upd
);

    wr_kind_e      kind;
    logic [DW-1:0] byte_word;
    logic [DW-1:0] bit_mask;

    assign kind     = wr_kind_e'(wr_kind);
    assign bit_mask = one_hot_bit(bit_idx);

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        assign byte_word[i*BW +: BW] = byte_en[i] ? wdata[i*BW +: BW] : '0;
    end

    always_comb begin
        upd = '{vld: 1'b0, val: q};
        if (wr_en) begin
            unique case (kind)
                WK_WORD: upd = '{vld: 1'b1, val: wdata};
                WK_BYTE: upd = '{vld: |byte_en, val: byte_word};
                WK_BIT:  upd = '{vld: 1'b1,
                                 val: (q & ~bit_mask) | ({DW{bit_val}} & bit_mask)};
                default: upd = '{vld: 1'b0, val: q};
            endcase
        end
    end

endmodule

// File: rtl/sfr_hw_upd.sv
module sfr_hw_upd
    import sfr_cfg_pkg::*;
(
    input  logic [DW-1:0] q,
    input  logic          en,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] value,
    output upd_t          upd
);

    always_comb begin
        upd.vld = en;
        upd.val = (q & ~mask) | (value & mask);
    end

endmodule

// File: rtl/sfr_cfg_reg.sv
module sfr_cfg_reg
    import sfr_cfg_pkg::*;
#(
    parameter logic [DW-1:0] IMPL_MASK = 16'h7FEF,
    parameter logic [DW-1:0] RESET_VAL = 16'h0000,
    parameter logic [DW-1:0] LOAD_MASK = 16'h0680
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     cfg_pins,
    input  logic              cpu_wr_en,
    input  logic [1:0]        cpu_wr_kind,
    input  logic [NBYTES-1:0] cpu_byte_en,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [IDXW-1:0]   cpu_bit_idx,
    input  logic              cpu_bit_val,
    input  logic              hw_wr_en,
    input  logic [DW-1:0]     hw_mask,
    input  logic [DW-1:0]     hw_value,
    output logic [DW-1:0]     rd_data
);

    logic [DW-1:0] q;
    upd_t          cpu_upd;
    upd_t          hw_upd;

    sfr_cpu_wr u_cpu (
        .q       (q),
        .wr_en   (cpu_wr_en),
        .wr_kind (cpu_wr_kind),
        .byte_en (cpu_byte_en),
        .wdata   (cpu_wdata),
        .bit_idx (cpu_bit_idx),
        .bit_val (cpu_bit_val),
        .upd     (cpu_upd)
    );

    sfr_hw_upd u_hw (
        .q     (q),
        .en    (hw_wr_en),
        .mask  (hw_mask),
        .value (hw_value),
        .upd   (hw_upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= strap_value(RESET_VAL, LOAD_MASK, cfg_pins) & IMPL_MASK;
        end else if (cpu_upd.vld) begin
            q <= cpu_upd.val & IMPL_MASK;
        end else if (hw_upd.vld) begin
            q <= hw_upd.val & IMPL_MASK;
        end
    end

    assign rd_data = q;

endmodule

// File: rtl/sfr_cfg_reg_chk.sv
module sfr_cfg_reg_chk
    import sfr_cfg_pkg::*;
#(
    parameter logic [DW-1:0] IMPL_MASK = 16'h7FEF
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_wr_en,
    input logic [1:0]        cpu_wr_kind,
    input logic [NBYTES-1:0] cpu_byte_en,
    input logic [DW-1:0]     cpu_wdata,
    input logic [IDXW-1:0]   cpu_bit_idx,
    input logic              hw_wr_en,
    input logic [DW-1:0]     hw_mask,
    input logic [DW-1:0]     rd_data
);

    logic [DW-1:0] sel_bit;
    logic          word_wr;
    logic          lo_only;
    logic          hi_only;
    logic          bit_wr;
    logic          cpu_none;

    assign sel_bit  = one_hot_bit(cpu_bit_idx);
    assign word_wr  = cpu_wr_en && (cpu_wr_kind == 2'd0);
    assign lo_only  = cpu_wr_en && (cpu_wr_kind == 2'd1) && (cpu_byte_en == 2'b01);
    assign hi_only  = cpu_wr_en && (cpu_wr_kind == 2'd1) && (cpu_byte_en == 2'b10);
    assign bit_wr   = cpu_wr_en && (cpu_wr_kind == 2'd2);
    assign cpu_none = !cpu_wr_en || (cpu_wr_kind == 2'd3) ||
                      ((cpu_wr_kind == 2'd1) && (cpu_byte_en == 2'b00));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~IMPL_MASK) == '0);

    p_sw_wins_r1: assert property (@(posedge clk) disable iff (rst)
        (word_wr && hw_wr_en) |=> rd_data == ($past(cpu_wdata) & IMPL_MASK));

    p_low_byte_clears_high_r3: assert property (@(posedge clk) disable iff (rst)
        lo_only |=> rd_data[15:8] == 8'h00);

    p_high_byte_clears_low_r3: assert property (@(posedge clk) disable iff (rst)
        hi_only |=> rd_data[7:0] == 8'h00);

    p_bit_write_local_r5: assert property (@(posedge clk) disable iff (rst)
        bit_wr |=> ((rd_data ^ $past(rd_data)) & ~$past(sel_bit)) == '0);

    p_hw_masked_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_none && hw_wr_en) |=> ((rd_data ^ $past(rd_data)) & ~$past(hw_mask)) == '0);

    p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_none && !hw_wr_en) |=> $stable(rd_data));

endmodule

bind sfr_cfg_reg sfr_cfg_reg_chk #(.IMPL_MASK(IMPL_MASK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_wr_kind (cpu_wr_kind),
    .cpu_byte_en (cpu_byte_en),
    .cpu_wdata   (cpu_wdata),
    .cpu_bit_idx (cpu_bit_idx),
    .hw_wr_en    (hw_wr_en),
    .hw_mask     (hw_mask),
    .rd_data     (rd_data)
);

// File: tb/sfr_cfg_reg_tb.sv
module sfr_cfg_reg_tb;

    localparam logic [15:0] IMPL = 16'h7FEF;
    localparam logic [15:0] LOAD = 16'h0680;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_pins = 16'h0000;
    logic        cpu_wr_en = 1'b0;
    logic [1:0]  cpu_wr_kind = 2'd3;
    logic [1:0]  cpu_byte_en = 2'b00;
    logic [15:0] cpu_wdata = 16'h0000;
    logic [3:0]  cpu_bit_idx = 4'd0;
    logic        cpu_bit_val = 1'b0;
    logic        hw_wr_en = 1'b0;
    logic [15:0] hw_mask = 16'h0000;
    logic [15:0] hw_value = 16'h0000;
    logic [15:0] rd_data;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [15:0] exp_q = 16'h0000;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sfr_cfg_reg u_dut (
        .clk(clk), .rst(rst), .cfg_pins(cfg_pins),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_kind(cpu_wr_kind), .cpu_byte_en(cpu_byte_en),
        .cpu_wdata(cpu_wdata), .cpu_bit_idx(cpu_bit_idx), .cpu_bit_val(cpu_bit_val),
        .hw_wr_en(hw_wr_en), .hw_mask(hw_mask), .hw_value(hw_value),
        .rd_data(rd_data)
    );

    function automatic logic [15:0] model(input logic [15:0] q,
        input logic en, input logic [1:0] kind, input logic [1:0] be,
        input logic [15:0] wd, input logic [3:0] idx, input logic bv,
        input logic hen, input logic [15:0] hm, input logic [15:0] hv);
        logic [15:0] r;
        bit          took;
        r = q;
        took = 0;
        if (en) begin
            if (kind == 2'd0) begin
                r = wd; took = 1;
            end else if (kind == 2'd1 && be != 2'b00) begin
                r = {be[1] ? wd[15:8] : 8'h00, be[0] ? wd[7:0] : 8'h00};
                took = 1;
            end else if (kind == 2'd2) begin
                r[idx] = bv; took = 1;
            end
        end
        if (!took && hen) r = (q & ~hm) | (hv & hm);
        return r & IMPL;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic en, input logic [1:0] kind, input logic [1:0] be,
                       input logic [15:0] wd, input logic [3:0] idx, input logic bv,
                       input logic hen, input logic [15:0] hm, input logic [15:0] hv,
                       input string tag, input bit chk_old);
        logic [15:0] old;
        cpu_wr_en = en; cpu_wr_kind = kind; cpu_byte_en = be; cpu_wdata = wd;
        cpu_bit_idx = idx; cpu_bit_val = bv;
        hw_wr_en = hen; hw_mask = hm; hw_value = hv;
        old = exp_q;
        #1;
        if (chk_old) check(rd_data, old, "R9 same-cycle read shows old value");
        exp_q = model(exp_q, en, kind, be, wd, idx, bv, hen, hm, hv);
        @(negedge clk);
        check(rd_data, exp_q, tag);
    endtask

    task automatic do_reset(input logic [15:0] pins);
        rst = 1'b1; cfg_pins = pins;
        cpu_wr_en = 1'b0; hw_wr_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cfg_pins = ~pins;
        exp_q = ((16'h0000 & ~LOAD) | (pins & LOAD)) & IMPL;
        check(rd_data, exp_q, "R8 reset strap load");
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        cfg_pins = 16'hFFFF;
        @(negedge clk);
        do_reset(16'hFFFF);
        do_reset(16'h0000);
        do_reset(16'h0480);

        cyc(1, 2'd3, 2'b00, 16'hFFFF, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R10 kind 3 ignored", 0);
        cyc(1, 2'd0, 2'b00, 16'hFFFF, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R2 word write", 1);
        check(rd_data & ~IMPL, 16'h0000, "R7 reserved bits after word write");
        cyc(1, 2'd1, 2'b01, 16'hA5C3, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R3 low byte clears high", 1);
        cyc(1, 2'd0, 2'b00, 16'hFFFF, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R2 word write refill", 0);
        cyc(1, 2'd1, 2'b10, 16'h5A3C, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R3 high byte clears low", 1);
        cyc(1, 2'd1, 2'b11, 16'h1357, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R2 both strobes full word", 0);
        cyc(1, 2'd1, 2'b00, 16'hFFFF, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R4 empty strobes hold", 0);
        cyc(1, 2'd1, 2'b00, 16'h0000, 4'd0, 1'b0, 1, 16'hF00F, 16'hA00A, "R4 empty strobes hw passes", 0);
        cyc(1, 2'd2, 2'b00, 16'h0000, 4'd14, 1'b1, 0, 16'h0, 16'h0, "R5 bit set", 1);
        cyc(1, 2'd2, 2'b00, 16'hFFFF, 4'd0, 1'b0, 0, 16'h0, 16'h0, "R5 bit clear", 0);
        cyc(1, 2'd2, 2'b00, 16'h0000, 4'd15, 1'b1, 0, 16'h0, 16'h0, "R7 bit set on reserved bit", 0);
        cyc(1, 2'd2, 2'b00, 16'h0000, 4'd4, 1'b1, 0, 16'h0, 16'h0, "R7 bit set on reserved bit 4", 0);
        cyc(0, 2'd0, 2'b00, 16'h0000, 4'd0, 1'b0, 1, 16'h00FF, 16'h0F0F, "R6 hw masked update", 1);
        cyc(0, 2'd0, 2'b00, 16'h0000, 4'd0, 1'b0, 1, 16'hFFFF, 16'hFFFF, "R7 hw all ones", 0);
        cyc(1, 2'd0, 2'b00, 16'h0000, 4'd0, 1'b0, 1, 16'hFFFF, 16'hFFFF, "R1 word write beats hw", 0);
        cyc(1, 2'd1, 2'b01, 16'h00AA, 4'd0, 1'b0, 1, 16'hFF00, 16'hFF00, "R1 byte write beats hw", 0);
        cyc(1, 2'd2, 2'b00, 16'h0000, 4'd3, 1'b1, 1, 16'hFF00, 16'hFF00, "R1 bit write beats hw", 0);
        cyc(0, 2'd0, 2'b00, 16'hFFFF, 4'd0, 1'b0, 0, 16'hFFFF, 16'hFFFF, "R10 no write holds", 0);

        for (int i = 0; i < 600; i++) begin
            logic        en, hen, bv;
            logic [1:0]  kind, be;
            logic [15:0] wd, hm, hv;
            logic [3:0]  idx;
            string       tag;
            en   = ($urandom % 3) != 0;
            hen  = ($urandom % 2) != 0;
            kind = 2'($urandom);
            be   = 2'($urandom);
            wd   = 16'($urandom);
            hm   = 16'($urandom);
            hv   = 16'($urandom);
            idx  = 4'($urandom);
            bv   = 1'($urandom);
            if (en && hen && (kind == 2'd0 || kind == 2'd2 || (kind == 2'd1 && be != 2'b00)))
                tag = "R1 random collision";
            else if (en && kind == 2'd0) tag = "R2 random word";
            else if (en && kind == 2'd1 && (be == 2'b01 || be == 2'b10)) tag = "R3 random byte";
            else if (en && kind == 2'd1 && be == 2'b11) tag = "R2 random both strobes";
            else if (en && kind == 2'd1) tag = "R4 random empty strobes";
            else if (en && kind == 2'd2) tag = "R5 random bit";
            else if (hen) tag = "R6 random hw";
            else tag = "R10 random idle";
            cyc(en, kind, be, wd, idx, bv, hen, hm, hv, tag, (i % 8) == 0);
            if ((i % 16) == 0) check(rd_data & ~IMPL, 16'h0000, "R7 random reserved bits");
        end

        do_reset(16'h0280);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule